// File: doc/BRIEF.md
# Clause 22 MDIO Management Master

This block drives a clause 22 management bus towards one or more PHYs. Software talks to it through a small word-addressed register port with two registers. The command gateway holds one whole transaction: the 16-bit data value, the PHY address, the register address, the opcode, a start field and a busy flag. The timing register holds the MDC half-period and two sampling offsets, all counted in core clocks.

A gateway write with the busy flag set launches one frame. Each frame is 64 MDC cycles long: 32 preamble ones, the start pattern 01, the opcode, the PHY address, the register address, a two-bit turnaround and 16 data bits. All fields are sent most significant bit first. The busy flag stays set until the last MDC cycle ends. On a read, the master releases MDIO from the turnaround onward and samples the PHY. The 16 captured bits replace the low half of the gateway word, so software polls busy and then reads its data from the same register. A gateway write of all zeros cancels whatever is in progress.

Top module: `mdio_gw_master`

## Requirements
- R1: After reset, both registers read zero, MDC is low and the MDIO output enable is low.
- R2: Word address 0 (byte offset 0x0) is the gateway and word address 1 (byte offset 0x4) is the timing register. Gateway fields are: data 15:0, register address 20:16, PHY address 25:21, opcode 27:26, start field 28, busy 30. Bits 29 and 31 read as zero. A gateway write with busy clear only stores the fields and starts no frame.
- R3: A gateway write with bit 30 set, made while busy is clear, starts a frame. Busy then reads 1 for exactly 128*(P+1) core clocks, where P is timing bits 15:8. Busy is cleared only at the end of the frame or by an abort.
- R4: MDC has a period of 2*(P+1) core clocks: a low half of P+1 clocks followed by a high half of P+1 clocks. MDC stays low whenever busy is clear.
- R5: The bits seen at the 64 MDC rising edges are 32 ones, then 0,1, then opcode, PHY address and register address, then turnaround and data, each field MSB first.
- R6: For any opcode other than 2 (opcode 1 is write), the output enable is high at every rising edge of the frame, the turnaround is 1,0 and the data bits come from gateway bits 15:0.
- R7: For opcode 2 (read), the output enable is high for the first 46 bits and low for the last 18. When the frame ends, gateway bits 15:0 hold the captured value and bits 28:16 keep the command.
- R8: MDIO output and output-enable changes occur exactly min(O,P)+1 core clocks after the MDC falling edge, or after the command is accepted for the first bit. O is timing bits 31:24.
- R9: During a read, each data bit is taken from MDIO input in the single core clock cycle that lies min(I,P) clocks after the MDC rising edge. I is timing bits 23:16.
- R10: A gateway write with a nonzero value that arrives while busy is set is ignored. It does not change the stored command, the frame on the wire or the busy duration.
- R11: A gateway write of zero clears the gateway, and on the next cycle busy, MDC and output enable are all low. MDC then stays low, and the next command runs a normal frame.
- R12: Timing bits 1:0, 2 and 4 are stored and read back but do not change the frame timing. Timing bits 3, 5, 6 and 7 read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wen | input | 1 | Register write strobe |
| reg_addr | input | 1 | Word address: 0 gateway, 1 timing |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Read data of the addressed register (combinational) |
| mdio_i | input | 1 | MDIO pin input |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | MDIO output value |
| mdio_oe | output | 1 | MDIO output enable |

## Verification
The properties assume that software changes the timing register only while busy is clear, because a mid-frame change would break the link between the MDC edges and the strobes. They also assume that the register port performs at most one write per clock. The bench writes the timing register only between frames and uses single-cycle write pulses. It sweeps every period from 0 to 3 and places the sampling points below, at and above the half-period, which exercises the clamping. Its PHY model drives the inverted bit in every cycle except the expected sample cycle, so a read is correct only if the master samples in exactly that cycle.

// File: rtl/mdio_gw_pkg.sv
package mdio_gw_pkg;

    localparam int unsigned REG_W     = 32;
    localparam int unsigned TIME_W    = 8;
    localparam int unsigned DATA_W    = 16;
    localparam int unsigned PAD_W     = 5;
    localparam int unsigned PRE_LEN   = 32;
    localparam int unsigned BODY_LEN  = 32;
    localparam int unsigned FRAME_LEN = PRE_LEN + BODY_LEN;
    localparam int unsigned IDX_W     = $clog2(FRAME_LEN);
    localparam int unsigned BODY_AW   = $clog2(BODY_LEN);
    // bit positions within the 64-bit frame, counted from the first preamble bit
    localparam int unsigned TA_POS    = PRE_LEN + 14;
    localparam int unsigned DATA_POS  = TA_POS + 2;

    localparam logic [1:0] OP_WRITE = 2'd1;
    localparam logic [1:0] OP_READ  = 2'd2;

    // gateway word, most significant field first
    typedef struct packed {
        logic              rsv31;
        logic              busy;
        logic              rsv29;
        logic              st;
        logic [1:0]        op;
        logic [PAD_W-1:0]  phy;
        logic [PAD_W-1:0]  regad;
        logic [DATA_W-1:0] data;
    } gw_t;

    // timing word, most significant field first
    typedef struct packed {
        logic [TIME_W-1:0] out_pt;
        logic [TIME_W-1:0] in_pt;
        logic [TIME_W-1:0] period;
        logic [2:0]        rsv7_5;
        logic              drive;
        logic              rsv3;
        logic              volt;
        logic [1:0]        mode;
    } cfg_t;

    typedef enum logic {ENG_IDLE, ENG_RUN} eng_e;

    function automatic gw_t gw_clean(input logic [REG_W-1:0] w);
        gw_t g;
        g       = gw_t'(w);
        g.rsv31 = 1'b0;
        g.rsv29 = 1'b0;
        return g;
    endfunction

    function automatic cfg_t cfg_clean(input logic [REG_W-1:0] w);
        cfg_t c;
        c        = cfg_t'(w);
        c.rsv7_5 = '0;
        c.rsv3   = 1'b0;
        return c;
    endfunction

    function automatic logic [TIME_W-1:0] clamp_pt(input logic [TIME_W-1:0] pt,
                                                   input logic [TIME_W-1:0] per);
        return (pt > per) ? per : pt;
    endfunction

    // everything after the preamble; released bits of a read are filled with zero
    function automatic logic [BODY_LEN-1:0] frame_body(input gw_t g);
        logic rd;
        rd = (g.op == OP_READ);
        return {2'b01, g.op, g.phy, g.regad,
                (rd ? 2'b00 : 2'b10),
                (rd ? {DATA_W{1'b0}} : g.data)};
    endfunction

endpackage

// File: rtl/mdio_mdc_timebase.sv
module mdio_mdc_timebase
    import mdio_gw_pkg::*;
#(
    parameter int unsigned TW = TIME_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          en,
    input  logic [TW-1:0] period,
    input  logic [TW-1:0] out_pt,
    input  logic [TW-1:0] in_pt,
    output logic          mdc,
    output logic          drive_stb,
    output logic          samp_stb,
    output logic          cyc_end
);

    logic [TW-1:0] hc_q;
    logic          mdc_q;
    logic [TW-1:0] o_eff;
    logic [TW-1:0] i_eff;
    logic          half_end;

    assign o_eff    = (out_pt > period) ? period : out_pt;
    assign i_eff    = (in_pt  > period) ? period : in_pt;
    assign half_end = (hc_q >= period);

    always_ff @(posedge clk) begin
        if (rst) begin
            hc_q  <= '0;
            mdc_q <= 1'b0;
        end else if (!en) begin
            hc_q  <= '0;
            mdc_q <= 1'b0;
        end else if (half_end) begin
            hc_q  <= '0;
            mdc_q <= ~mdc_q;
        end else begin
            hc_q  <= hc_q + 1'b1;
        end
    end

    assign mdc       = mdc_q;
    assign drive_stb = en && !mdc_q && (hc_q == o_eff);
    assign samp_stb  = en &&  mdc_q && (hc_q == i_eff);
    assign cyc_end   = en &&  mdc_q && half_end;

endmodule

// File: rtl/mdio_frame_shifter.sv
module mdio_frame_shifter
    import mdio_gw_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic              abort,
    input  gw_t               cmd,
    input  logic              drive_stb,
    input  logic              samp_stb,
    input  logic              cyc_end,
    input  logic              mdio_i,
    output logic              running,
    output logic              mdio_o,
    output logic              mdio_oe,
    output logic              done,
    output logic [DATA_W-1:0] rd_data
);

    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(FRAME_LEN - 1);
    localparam logic [IDX_W-1:0] PRE_END  = IDX_W'(PRE_LEN);
    localparam logic [IDX_W-1:0] TA_IDX   = IDX_W'(TA_POS);
    localparam logic [IDX_W-1:0] DAT_IDX  = IDX_W'(DATA_POS);

    eng_e                state_q;
    logic [IDX_W-1:0]    bit_idx;
    logic [BODY_LEN-1:0] body_q;
    logic                is_rd_q;
    logic [DATA_W-1:0]   rd_sh_q;
    logic                o_q;
    logic                oe_q;

    logic [IDX_W-1:0]    rev_idx;
    logic                cur_bit;
    logic                capture;
    logic [DATA_W-1:0]   rd_next;
    logic                last_bit;

    assign rev_idx  = LAST_IDX - bit_idx;
    assign cur_bit  = (bit_idx < PRE_END) ? 1'b1 : body_q[rev_idx[BODY_AW-1:0]];
    assign running  = (state_q == ENG_RUN);
    assign capture  = running && samp_stb && is_rd_q && (bit_idx >= DAT_IDX);
    assign rd_next  = capture ? {rd_sh_q[DATA_W-2:0], mdio_i} : rd_sh_q;
    assign last_bit = (bit_idx == LAST_IDX);

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ENG_IDLE;
            bit_idx <= '0;
            body_q  <= '0;
            is_rd_q <= 1'b0;
            rd_sh_q <= '0;
            o_q     <= 1'b0;
            oe_q    <= 1'b0;
        end else if (abort) begin
            state_q <= ENG_IDLE;
            oe_q    <= 1'b0;
        end else if (state_q == ENG_IDLE) begin
            if (start) begin
                state_q <= ENG_RUN;
                bit_idx <= '0;
                body_q  <= frame_body(cmd);
                is_rd_q <= (cmd.op == OP_READ);
                rd_sh_q <= '0;
            end
        end else begin
            if (drive_stb) begin
                o_q  <= cur_bit;
                oe_q <= !(is_rd_q && (bit_idx >= TA_IDX));
            end
            rd_sh_q <= rd_next;
            if (cyc_end) begin
                if (last_bit) begin
                    state_q <= ENG_IDLE;
                    oe_q    <= 1'b0;
                end else begin
                    bit_idx <= bit_idx + 1'b1;
                end
            end
        end
    end

    assign mdio_o  = o_q;
    assign mdio_oe = oe_q;
    assign done    = running && cyc_end && last_bit;
    assign rd_data = rd_next;

endmodule

// File: rtl/mdio_gw_regs.sv
module mdio_gw_regs
    import mdio_gw_pkg::*;
#(
    parameter int unsigned AW = 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wen,
    input  logic [AW-1:0]     addr,
    input  logic [REG_W-1:0]  wdata,
    output logic [REG_W-1:0]  rdata,
    input  logic              done,
    input  logic [DATA_W-1:0] rd_data,
    output logic              start,
    output logic              abort,
    output gw_t               cmd,
    output gw_t               gw_cur,
    output cfg_t              cfg_cur
);

    localparam logic [AW-1:0] GW_ADDR  = AW'(0);
    localparam logic [AW-1:0] CFG_ADDR = AW'(1);

    gw_t  gw_q;
    cfg_t cfg_q;
    logic gw_sel;
    logic zero_wr;
    logic accept;

    assign gw_sel  = wen && (addr == GW_ADDR);
    assign zero_wr = (wdata == '0);
    assign abort   = gw_sel && zero_wr;
    assign accept  = gw_sel && !zero_wr && !gw_q.busy;
    assign cmd     = gw_clean(wdata);
    assign start   = accept && cmd.busy;

    always_ff @(posedge clk) begin
        if (rst) begin
            gw_q <= '0;
        end else if (abort) begin
            gw_q <= '0;
        end else if (accept) begin
            gw_q <= cmd;
        end else if (done) begin
            gw_q.busy <= 1'b0;
            if (gw_q.op == OP_READ) begin
                gw_q.data <= rd_data;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q <= '0;
        end else if (wen && (addr == CFG_ADDR)) begin
            cfg_q <= cfg_clean(wdata);
        end
    end

    always_comb begin
        if (addr == GW_ADDR) begin
            rdata = gw_q;
        end else if (addr == CFG_ADDR) begin
            rdata = cfg_q;
        end else begin
            rdata = '0;
        end
    end

    assign gw_cur  = gw_q;
    assign cfg_cur = cfg_q;

endmodule

// File: rtl/mdio_gw_master.sv
module mdio_gw_master
    import mdio_gw_pkg::*;
#(
    parameter int unsigned REG_AW = 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_wen,
    input  logic [REG_AW-1:0] reg_addr,
    input  logic [REG_W-1:0]  reg_wdata,
    output logic [REG_W-1:0]  reg_rdata,
    input  logic              mdio_i,
    output logic              mdc,
    output logic              mdio_o,
    output logic              mdio_oe
);

    gw_t               gw_cur;
    cfg_t              cfg_cur;
    gw_t               cmd_word;
    logic              start_req;
    logic              abort_req;
    logic              done;
    logic [DATA_W-1:0] rd_data;
    logic              running;
    logic              tb_en;
    logic              drive_stb;
    logic              samp_stb;
    logic              cyc_end;
    logic              busy;
    logic [REG_W-1:0]  gw_word;

    assign busy    = gw_cur.busy;
    assign gw_word = gw_cur;
    assign tb_en   = running && !abort_req;

    mdio_gw_regs #(.AW(REG_AW)) u_regs (
        .clk     (clk),
        .rst     (rst),
        .wen     (reg_wen),
        .addr    (reg_addr),
        .wdata   (reg_wdata),
        .rdata   (reg_rdata),
        .done    (done),
        .rd_data (rd_data),
        .start   (start_req),
        .abort   (abort_req),
        .cmd     (cmd_word),
        .gw_cur  (gw_cur),
        .cfg_cur (cfg_cur)
    );

    mdio_mdc_timebase #(.TW(TIME_W)) u_time (
        .clk       (clk),
        .rst       (rst),
        .en        (tb_en),
        .period    (cfg_cur.period),
        .out_pt    (cfg_cur.out_pt),
        .in_pt     (cfg_cur.in_pt),
        .mdc       (mdc),
        .drive_stb (drive_stb),
        .samp_stb  (samp_stb),
        .cyc_end   (cyc_end)
    );

    mdio_frame_shifter u_shift (
        .clk       (clk),
        .rst       (rst),
        .start     (start_req),
        .abort     (abort_req),
        .cmd       (cmd_word),
        .drive_stb (drive_stb),
        .samp_stb  (samp_stb),
        .cyc_end   (cyc_end),
        .mdio_i    (mdio_i),
        .running   (running),
        .mdio_o    (mdio_o),
        .mdio_oe   (mdio_oe),
        .done      (done),
        .rd_data   (rd_data)
    );

endmodule

// File: rtl/mdio_gw_checks.sv
module mdio_gw_checks (
    input logic        clk,
    input logic        rst,
    input logic        reg_wen,
    input logic        reg_addr,
    input logic [31:0] reg_wdata,
    input logic        busy,
    input logic [31:0] gw_word,
    input logic        drive_stb,
    input logic        done,
    input logic        abort_req,
    input logic        mdc,
    input logic        mdio_o,
    input logic        mdio_oe
);

    AST_MDC_IDLE_LOW: assert property (@(posedge clk) disable iff (rst)
        !busy |-> !mdc); // R4

    AST_BUSY_CLEAR_CAUSE: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> $past(done || abort_req)); // R3

    AST_OUT_AT_DRIVE_POINT: assert property (@(posedge clk) disable iff (rst)
        !$stable(mdio_o) |-> $past(drive_stb)); // R8

    AST_OE_RISE_AT_DRIVE: assert property (@(posedge clk) disable iff (rst)
        $rose(mdio_oe) |-> $past(drive_stb)); // R6

    AST_IGNORE_WHILE_BUSY: assert property (@(posedge clk) disable iff (rst)
        (busy && reg_wen && !reg_addr && (reg_wdata != 32'd0)) |=> $stable(gw_word[28:16])); // R10

    AST_ABORT_TO_IDLE: assert property (@(posedge clk) disable iff (rst)
        (reg_wen && !reg_addr && (reg_wdata == 32'd0)) |=> (!busy && !mdc && !mdio_oe)); // R11

endmodule

bind mdio_gw_master mdio_gw_checks u_checks (
    .clk       (clk),
    .rst       (rst),
    .reg_wen   (reg_wen),
    .reg_addr  (reg_addr[0]),
    .reg_wdata (reg_wdata),
    .busy      (busy),
    .gw_word   (gw_word),
    .drive_stb (drive_stb),
    .done      (done),
    .abort_req (abort_req),
    .mdc       (mdc),
    .mdio_o    (mdio_o),
    .mdio_oe   (mdio_oe)
);

// File: tb/sim_mdio_gw_master.sv
module sim_mdio_gw_master;

    logic        clk = 1'b0;
    logic        rst;
    logic        reg_wen;
    logic [0:0]  reg_addr;
    logic [31:0] reg_wdata;
    logic [31:0] reg_rdata;
    logic        mdio_i;
    logic        mdc;
    logic        mdio_o;
    logic        mdio_oe;

    mdio_gw_master u0 (
        .clk       (clk),
        .rst       (rst),
        .reg_wen   (reg_wen),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .mdio_i    (mdio_i),
        .mdc       (mdc),
        .mdio_o    (mdio_o),
        .mdio_oe   (mdio_oe)
    );

    always #10 clk = ~clk;

    int checks = 0;
    int fails  = 0;

    // PHY model and monitor state
    longint      cyc = 0;
    longint      last_rise = 0;
    longint      t_rise = 0;
    longint      t_fall = 0;
    logic        mdc_prev = 1'b0;
    logic        o_prev = 1'b0;
    logic        busy_prev = 1'b0;
    bit          fell_seen = 1'b0;
    int          since_rise = 0;
    int          since_fall = 0;
    int          rise_cnt = 0;
    int          bad_per = 0;
    int          bad_delay = 0;
    int          high_cnt = 0;
    int          exp_per = 2;
    int          exp_od = 1;
    int          exp_ip = 0;
    logic [15:0] phy_val = 16'h0;
    logic [63:0] cap_w = 64'h0;
    logic [63:0] cap_oe = 64'h0;

    task automatic check(input bit ok, input string req, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    always @(negedge clk) begin
        logic busy_now;
        logic bv;
        cyc++;
        busy_now = (reg_addr == 1'b0) && reg_rdata[30];
        if (mdc) high_cnt++;
        if (mdc && !mdc_prev) begin
            if (rise_cnt > 0 && (cyc - last_rise) != longint'(exp_per)) bad_per++;
            last_rise  = cyc;
            since_rise = 0;
            if (rise_cnt < 64) begin
                cap_w[63 - rise_cnt]  = mdio_oe ? mdio_o : 1'b1;
                cap_oe[63 - rise_cnt] = mdio_oe;
            end
            rise_cnt++;
        end else begin
            since_rise++;
        end
        if ((!mdc && mdc_prev) || (busy_now && !busy_prev)) since_fall = 0;
        else since_fall++;
        if (mdio_o !== o_prev && since_fall != exp_od) bad_delay++;
        if (busy_now && !busy_prev) t_rise = cyc;
        if (!busy_now && busy_prev) begin
            t_fall    = cyc;
            fell_seen = 1'b1;
        end
        // data bits: correct value only in the expected sampling cycle
        if (mdc && rise_cnt >= 49 && rise_cnt <= 64) begin
            bv     = phy_val[64 - rise_cnt];
            mdio_i = (since_rise == exp_ip) ? bv : ~bv;
        end else begin
            mdio_i = 1'b1;
        end
        mdc_prev  = mdc;
        o_prev    = mdio_o;
        busy_prev = busy_now;
    end

    task automatic wr(input logic a, input logic [31:0] d);
        @(posedge clk); #2;
        reg_addr  = a;
        reg_wdata = d;
        reg_wen   = 1'b1;
        @(posedge clk); #2;
        reg_wen   = 1'b0;
        reg_addr  = 1'b0;
        reg_wdata = 32'h0;
    endtask

    task automatic arm(input int p, input int ip, input int op_pt, input logic [15:0] v);
        @(posedge clk); #1;
        rise_cnt  = 0;
        bad_per   = 0;
        bad_delay = 0;
        fell_seen = 1'b0;
        cap_w     = 64'h0;
        cap_oe    = 64'h0;
        exp_per   = 2 * (p + 1);
        exp_od    = ((op_pt > p) ? p : op_pt) + 1;
        exp_ip    = (ip > p) ? p : ip;
        phy_val   = v;
    endtask

    task automatic wait_idle();
        for (int n = 0; n < 70000 && !fell_seen; n++) @(negedge clk);
        @(posedge clk); #2;
    endtask

    function automatic logic [31:0] make_gw(input logic [1:0] op, input logic [4:0] phy,
                                            input logic [4:0] rg, input logic [15:0] d,
                                            input logic b);
        return {1'b0, b, 1'b0, 1'b1, op, phy, rg, d};
    endfunction

    function automatic logic [63:0] exp_frame(input logic [1:0] op, input logic [4:0] phy,
                                              input logic [4:0] rg, input logic [15:0] d);
        return {32'hFFFF_FFFF, 2'b01, op, phy, rg, 2'b10, d};
    endfunction

    task automatic frame_checks(input int p, input logic [1:0] op, input logic [4:0] phy,
                                input logic [4:0] rg, input logic [15:0] d, input logic [15:0] v);
        logic [63:0] ef;
        ef = exp_frame(op, phy, rg, d);
        check((t_fall - t_rise) == longint'(128 * (p + 1)), "R3", "busy length",
              64'(t_fall - t_rise), 64'(128 * (p + 1)));
        check(bad_per == 0, "R4", "mdc period errors", 64'(bad_per), 64'd0);
        check(mdc == 1'b0, "R4", "mdc idle level", 64'(mdc), 64'd0);
        check(rise_cnt == 64, "R5", "rising edges per frame", 64'(rise_cnt), 64'd64);
        check(bad_delay == 0, "R8", "output change delay errors", 64'(bad_delay), 64'd0);
        if (op == 2'd2) begin
            check(cap_w[63:18] == ef[63:18], "R5", "read frame header", 64'(cap_w[63:18]), 64'(ef[63:18]));
            check(cap_oe == {{46{1'b1}}, 18'h0}, "R7", "read output enable", cap_oe, {{46{1'b1}}, 18'h0});
            check(reg_rdata[15:0] == v, "R9", "read data", 64'(reg_rdata[15:0]), 64'(v));
            check(reg_rdata[31:16] == {3'b000, 1'b1, op, phy, rg}, "R7", "read command kept",
                  64'(reg_rdata[31:16]), 64'({3'b000, 1'b1, op, phy, rg}));
        end else begin
            check(cap_w == ef, "R6", "write frame", cap_w, ef);
            check(cap_oe == {64{1'b1}}, "R6", "write output enable", cap_oe, {64{1'b1}});
            check(reg_rdata == make_gw(op, phy, rg, d, 1'b0), "R6", "gateway after write",
                  64'(reg_rdata), 64'(make_gw(op, phy, rg, d, 1'b0)));
        end
    endtask

    task automatic do_frame(input int p, input int ip, input int op_pt, input logic [7:0] low8,
                            input logic [1:0] op, input logic [4:0] phy, input logic [4:0] rg,
                            input logic [15:0] d, input logic [15:0] v);
        wr(1'b1, {8'(op_pt), 8'(ip), 8'(p), low8});
        arm(p, ip, op_pt, v);
        wr(1'b0, make_gw(op, phy, rg, d, 1'b1));
        wait_idle();
        frame_checks(p, op, phy, rg, d, v);
    endtask

    initial begin
        #3_000_000;
        fails++;
        $display("FAIL watchdog run did not finish actual=%0h expected=%0h", 0, 1);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        rst       = 1'b1;
        reg_wen   = 1'b0;
        reg_addr  = 1'b0;
        reg_wdata = 32'h0;
        mdio_i    = 1'b1;
        repeat (4) @(posedge clk);
        #2 rst = 1'b0;

        // R1 reset state
        @(negedge clk);
        check(reg_rdata == 32'h0, "R1", "gateway after reset", 64'(reg_rdata), 64'd0);
        check(mdc == 1'b0 && mdio_oe == 1'b0, "R1", "pins after reset", {62'd0, mdc, mdio_oe}, 64'd0);
        @(posedge clk); #2 reg_addr = 1'b1;
        @(negedge clk);
        check(reg_rdata == 32'h0, "R1", "timing after reset", 64'(reg_rdata), 64'd0);
        @(posedge clk); #2 reg_addr = 1'b0;

        // R2 field storage without start, R12 timing register masking
        wr(1'b0, 32'hBFFF_FFFF);
        high_cnt = 0;
        repeat (50) @(posedge clk);
        #2;
        @(negedge clk);
        check(reg_rdata == 32'h1FFF_FFFF, "R2", "gateway readback", 64'(reg_rdata), 64'h1FFF_FFFF);
        check(high_cnt == 0, "R2", "no frame without busy", 64'(high_cnt), 64'd0);
        wr(1'b1, 32'hFFFF_FFFF);
        @(posedge clk); #2 reg_addr = 1'b1;
        @(negedge clk);
        check(reg_rdata == 32'hFFFF_FF17, "R12", "timing readback", 64'(reg_rdata), 64'hFFFF_FF17);
        @(posedge clk); #2 reg_addr = 1'b0;

        // R12: pad bits set, timing unchanged
        do_frame(1, 0, 1, 8'h17, 2'd1, 5'h03, 5'h11, 16'hC35A, 16'h0);
        check((t_fall - t_rise) == 64'd256, "R12", "busy length with pad bits", 64'(t_fall - t_rise), 64'd256);

        // sweep of period and sampling points, write and read
        for (int p = 0; p < 4; p++) begin
            for (int j = 0; j < 3; j++) begin
                int ip;
                int opt;
                ip  = (j == 0) ? 0 : ((j == 1) ? p : p + 2);
                opt = (j == 0) ? p : ((j == 1) ? 0 : 9);
                do_frame(p, ip, opt, 8'h00, 2'd1, 5'(p * 7 + j), 5'(31 - p - j),
                         16'(16'hA5C3 + p * 16'h1111 + j * 16'h0202), 16'h0);
                do_frame(p, ip, opt, 8'h00, 2'd2, 5'(p + 20 + j), 5'(p * 3 + j),
                         16'h0, 16'(16'h5A3C + p * 16'h0101 + j * 16'h1230));
            end
        end

        // R10: second command while busy is ignored
        wr(1'b1, {8'd1, 8'd1, 8'd1, 8'h00});
        arm(1, 1, 1, 16'h0);
        wr(1'b0, make_gw(2'd1, 5'h0A, 5'h15, 16'h9669, 1'b1));
        repeat (40) @(posedge clk);
        wr(1'b0, make_gw(2'd2, 5'h1F, 5'h01, 16'h1234, 1'b1));
        @(negedge clk);
        check(reg_rdata == make_gw(2'd1, 5'h0A, 5'h15, 16'h9669, 1'b1), "R10", "command unchanged",
              64'(reg_rdata), 64'(make_gw(2'd1, 5'h0A, 5'h15, 16'h9669, 1'b1)));
        wait_idle();
        check((t_fall - t_rise) == 64'd256, "R10", "busy length unchanged", 64'(t_fall - t_rise), 64'd256);
        check(cap_w == exp_frame(2'd1, 5'h0A, 5'h15, 16'h9669), "R10", "frame unchanged",
              cap_w, exp_frame(2'd1, 5'h0A, 5'h15, 16'h9669));

        // R11: abort in the middle of a read
        wr(1'b1, {8'd2, 8'd1, 8'd3, 8'h00});
        arm(3, 1, 2, 16'hFFFF);
        wr(1'b0, make_gw(2'd2, 5'h05, 5'h02, 16'h0, 1'b1));
        repeat (150) @(posedge clk);
        wr(1'b0, 32'h0);
        @(negedge clk);
        check(reg_rdata == 32'h0, "R11", "gateway after abort", 64'(reg_rdata), 64'd0);
        check({mdc, mdio_oe} == 2'b00, "R11", "pins after abort", 64'({mdc, mdio_oe}), 64'd0);
        @(posedge clk); #1 high_cnt = 0;
        repeat (600) @(posedge clk);
        check(high_cnt == 0, "R11", "mdc quiet after abort", 64'(high_cnt), 64'd0);
        do_frame(2, 1, 1, 8'h00, 2'd2, 5'h07, 5'h1E, 16'h0, 16'hBEEF);
        check((t_fall - t_rise) == 64'd384, "R11", "frame after abort", 64'(t_fall - t_rise), 64'd384);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule